// File: doc/BRIEF.md
# Addressed Three-Wire Serial Control Port

This block is the slave side of a three-wire serial control link with an open-drain return line. A host drives a clock line, a data line and an enable line. While the enable line is low, the host clocks in an 8-bit address. Raising the enable line fixes the transfer mode that the address selects. There are two modes that load a 24-bit control word, one mode that reads back status, and all other addresses are ignored. A control word takes effect only when the enable line falls, and only if exactly 24 bits were clocked in. Each write mode has its own word register and a one-cycle load strobe for its consumers.

All three serial inputs and the two IO pad levels pass through a two-flop synchroniser into a fast system clock (16 MHz or more). Every edge is detected in that clock domain, so the clock line may rest high or low between transfers. The return line is modelled as an output enable: when `doOe` is 1 the pad is pulled low, and when it is 0 the pad is released. During a read, the pad carries the shifted status bits. When no transfer is active, a 3-bit selector from outside turns the pad into a lock, count-end or pin-mirror indicator.

Top module: `serialCtrlPort`

## Requirements
- R1: Address bits are received on each rising edge of the serial clock while enable is low, first bit first. Taking the first bit as bit 0, the last eight bits held when enable rises select the mode: 0x28 is write mode 1, 0x29 is write mode 2, 0x2A is read mode.
- R2: In a write mode, the first data bit after enable rises becomes bit 0 of the word. When enable falls after exactly 24 bits, the word is copied to `word1` (mode 1) or `word2` (mode 2) and the matching strobe pulses for one cycle.
- R3: If a write transfer ends with fewer or more than 24 data bits, both words stay unchanged and no strobe pulses.
- R4: A transfer under any other address changes no word, pulses no strobe and leaves `doOe` at 0 while enable is high.
- R5: In read mode the pad shows, in order, IO2, IO1, the lock flag, then count bits 19 down to 0. The first bit is present once enable has risen, each rising serial clock edge advances one bit, and the pad is released (`doOe`=0) for any bit after the 23rd. A bit of value 0 gives `doOe`=1.
- R6: The IO1 and IO2 levels sent in a read are the ones sampled when enable rose, whatever the pins do later and whatever their direction.
- R7: While enable is high in a write mode, `doOe` is 0 regardless of the selector.
- R8: With no transfer active, `doCtrl` selects the pad: 001 gives `doOe`=1 when `lockedIn` is 0; 010 gives `doOe`=`cntDoneIn`; 101 pulls low when IO1 is low; 110 pulls low when IO2 is low; every other code gives `doOe`=0.
- R9: For codes 101 and 110, `doOe` is 0 when the mirrored pin is marked as an output in `ioIsOut` (bit 0 for IO1, bit 1 for IO2).
- R10: Transfers behave the same whether the serial clock rests high or low.
- R11: After reset both words are zero, no strobe is active and `doOe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clIn | input | 1 | Serial clock line |
| diIn | input | 1 | Serial data line |
| ceIn | input | 1 | Transfer enable line |
| ioPinIn | input | 2 | Pad levels: bit 0 IO1, bit 1 IO2 |
| ioIsOut | input | 2 | 1 marks the IO pin as an output |
| lockedIn | input | 1 | Loop lock flag (1 locked) |
| cntDoneIn | input | 1 | Count measurement finished |
| countIn | input | CNT_BITS | Count value for read-back |
| doCtrl | input | 3 | Idle pad selector |
| word1 | output | WORD_BITS | Word of write mode 1 |
| word1Stb | output | 1 | One-cycle load pulse of word1 |
| word2 | output | WORD_BITS | Word of write mode 2 |
| word2Stb | output | 1 | One-cycle load pulse of word2 |
| doOe | output | 1 | 1 pulls the return pad low |

## Verification
A wrong mode decode or an off-by-one bit counter shows at the ports at the next enable fall. It appears as a word that changes when it should not, a missing or extra strobe, or a word whose bits are rotated by one position. A fault in the read shift register corrupts the very next bit the host samples, and a selector fault shows on `doOe` within a few system cycles of the inputs settling. The bench compares every word, strobe count and read bit with its own model, using random words, lengths, counts and resting clock levels, so such faults surface at the end of the transfer where they occur.

// File: rtl/scpPkg.sv
package scpPkg;
  localparam int ADDR_BITS = 8;

  localparam logic [ADDR_BITS-1:0] ADDR_WR1 = 8'h28;
  localparam logic [ADDR_BITS-1:0] ADDR_WR2 = 8'h29;
  localparam logic [ADDR_BITS-1:0] ADDR_RD  = 8'h2A;

  localparam logic [2:0] DOSEL_UNLOCK = 3'b001;
  localparam logic [2:0] DOSEL_CNTEND = 3'b010;
  localparam logic [2:0] DOSEL_IO1    = 3'b101;
  localparam logic [2:0] DOSEL_IO2    = 3'b110;

  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_WR1,
    MODE_WR2,
    MODE_RD,
    MODE_SKIP
  } modeE;

  typedef struct packed {
    logic addrShift;
    logic dataShift;
    logic latch1;
    logic latch2;
    logic outLoad;
    logic outShift;
    logic busy;
    logic inRead;
  } strobeT;
endpackage

// File: rtl/scpSync.sv
module scpSync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] st;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) st <= '0;
        else       st <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) st <= '0;
        else       st <= {st[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/scpCtrl.sv
module scpCtrl
  import scpPkg::*;
#(
  parameter int WORD_BITS = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clS,
  input  logic                 ceS,
  input  logic [ADDR_BITS-1:0] addrBits,
  output strobeT               stb
);
  localparam int SAT   = WORD_BITS + 1;
  localparam int CNT_W = $clog2(SAT + 1);

  logic clPrev, cePrev;
  logic clRise, ceRise, ceFall;
  modeE mode, decMode;
  logic [CNT_W-1:0] bitCnt;
  logic isWrite, fullWord;

  assign clRise = clS & ~clPrev;
  assign ceRise = ceS & ~cePrev;
  assign ceFall = ~ceS & cePrev;

  always_comb begin
    case (addrBits)
      ADDR_WR1: decMode = MODE_WR1;
      ADDR_WR2: decMode = MODE_WR2;
      ADDR_RD:  decMode = MODE_RD;
      default:  decMode = MODE_SKIP;
    endcase
  end

  assign isWrite  = (mode == MODE_WR1) || (mode == MODE_WR2);
  assign fullWord = (bitCnt == CNT_W'(WORD_BITS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clPrev <= 1'b0;
      cePrev <= 1'b0;
      mode   <= MODE_IDLE;
      bitCnt <= '0;
    end else begin
      clPrev <= clS;
      cePrev <= ceS;
      if (ceRise)      mode <= decMode;
      else if (ceFall) mode <= MODE_IDLE;
      if (ceRise)
        bitCnt <= '0;
      else if (stb.dataShift && bitCnt != CNT_W'(SAT))
        bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    stb           = '0;
    stb.addrShift = clRise & ~ceS;
    stb.dataShift = clRise & ceS & isWrite;
    stb.latch1    = ceFall & (mode == MODE_WR1) & fullWord;
    stb.latch2    = ceFall & (mode == MODE_WR2) & fullWord;
    stb.outLoad   = ceRise & (decMode == MODE_RD);
    stb.outShift  = clRise & ceS & (mode == MODE_RD);
    stb.busy      = ceS;
    stb.inRead    = (mode == MODE_RD);
  end

  // R3
  bit_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(SAT));

  // R2
  latch_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.latch1, stb.latch2}));

  // R1
  shift_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.addrShift, stb.dataShift, stb.outShift}));

  // R4
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ceS |=> mode == MODE_IDLE);
endmodule

// File: rtl/scpDatapath.sv
module scpDatapath
  import scpPkg::*;
#(
  parameter int WORD_BITS = 24,
  parameter int CNT_BITS  = 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               stb,
  input  logic                 diS,
  input  logic                 io1S,
  input  logic                 io2S,
  input  logic [1:0]           ioIsOut,
  input  logic                 lockedIn,
  input  logic                 cntDoneIn,
  input  logic [CNT_BITS-1:0]  countIn,
  input  logic [2:0]           doCtrl,
  output logic [ADDR_BITS-1:0] addrBits,
  output logic [WORD_BITS-1:0] word1,
  output logic                 word1Stb,
  output logic [WORD_BITS-1:0] word2,
  output logic                 word2Stb,
  output logic                 doOe
);
  localparam int OUT_W = CNT_BITS + 3;

  logic [WORD_BITS-1:0] dataSh;
  logic [OUT_W-1:0]     outSh;
  logic                 oeNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrBits <= '0;
      dataSh   <= '0;
      outSh    <= '1;
      word1    <= '0;
      word2    <= '0;
      word1Stb <= 1'b0;
      word2Stb <= 1'b0;
      doOe     <= 1'b0;
    end else begin
      if (stb.addrShift) addrBits <= {diS, addrBits[ADDR_BITS-1:1]};
      if (stb.dataShift) dataSh   <= {diS, dataSh[WORD_BITS-1:1]};
      if (stb.outLoad)
        outSh <= {io2S, io1S, lockedIn, countIn};
      else if (stb.outShift)
        outSh <= {outSh[OUT_W-2:0], 1'b1};
      if (stb.latch1) word1 <= dataSh;
      if (stb.latch2) word2 <= dataSh;
      word1Stb <= stb.latch1;
      word2Stb <= stb.latch2;
      doOe     <= oeNext;
    end
  end

  always_comb begin
    if (stb.inRead)
      oeNext = ~outSh[OUT_W-1];
    else if (stb.busy)
      oeNext = 1'b0;
    else begin
      case (doCtrl)
        DOSEL_UNLOCK: oeNext = ~lockedIn;
        DOSEL_CNTEND: oeNext = cntDoneIn;
        DOSEL_IO1:    oeNext = ~ioIsOut[0] & ~io1S;
        DOSEL_IO2:    oeNext = ~ioIsOut[1] & ~io2S;
        default:      oeNext = 1'b0;
      endcase
    end
  end

  // R3
  word1_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latch1 |=> $stable(word1));

  // R3
  word2_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latch2 |=> $stable(word2));

  // R5
  out_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.outShift |=> outSh[0]);

  // R7
  write_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.busy && !stb.inRead) |=> !doOe);

  // R2
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    word1Stb |=> !word1Stb);
endmodule

// File: rtl/serialCtrlPort.sv
module serialCtrlPort
  import scpPkg::*;
#(
  parameter int WORD_BITS   = 24,
  parameter int CNT_BITS    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clIn,
  input  logic                 diIn,
  input  logic                 ceIn,
  input  logic [1:0]           ioPinIn,
  input  logic [1:0]           ioIsOut,
  input  logic                 lockedIn,
  input  logic                 cntDoneIn,
  input  logic [CNT_BITS-1:0]  countIn,
  input  logic [2:0]           doCtrl,
  output logic [WORD_BITS-1:0] word1,
  output logic                 word1Stb,
  output logic [WORD_BITS-1:0] word2,
  output logic                 word2Stb,
  output logic                 doOe
);
  localparam int SYNC_W = 5;

  logic [SYNC_W-1:0]    syncQ;
  logic                 clS, diS, ceS, io1S, io2S;
  logic [ADDR_BITS-1:0] addrBits;
  strobeT               stb;

  scpSync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .d    ({ioPinIn[1], ioPinIn[0], ceIn, diIn, clIn}),
    .q    (syncQ)
  );

  assign {io2S, io1S, ceS, diS, clS} = syncQ;

  scpCtrl #(.WORD_BITS(WORD_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clS      (clS),
    .ceS      (ceS),
    .addrBits (addrBits),
    .stb      (stb)
  );

  scpDatapath #(.WORD_BITS(WORD_BITS), .CNT_BITS(CNT_BITS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .diS       (diS),
    .io1S      (io1S),
    .io2S      (io2S),
    .ioIsOut   (ioIsOut),
    .lockedIn  (lockedIn),
    .cntDoneIn (cntDoneIn),
    .countIn   (countIn),
    .doCtrl    (doCtrl),
    .addrBits  (addrBits),
    .word1     (word1),
    .word1Stb  (word1Stb),
    .word2     (word2),
    .word2Stb  (word2Stb),
    .doOe      (doOe)
  );
endmodule

// File: tb/serialCtrlPort_bench.sv
module serialCtrlPort_bench;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clIn = 1'b0, diIn = 1'b0, ceIn = 1'b0;
  logic [1:0] ioPinIn = 2'b11, ioIsOut = 2'b00;
  logic lockedIn = 1'b1, cntDoneIn = 1'b0;
  logic [19:0] countIn = '0;
  logic [2:0] doCtrl = 3'b000;
  logic [23:0] word1, word2;
  logic word1Stb, word2Stb, doOe;

  int total = 0, bad = 0;
  int stb1Cnt = 0, stb2Cnt = 0;
  bit finished = 0;
  logic clIdle = 1'b0;
  logic [23:0] exp1 = '0, exp2 = '0;

  always #5 clk = ~clk;

  serialCtrlPort u_serialCtrlPort (
    .clk(clk), .rstN(rstN), .clIn(clIn), .diIn(diIn), .ceIn(ceIn),
    .ioPinIn(ioPinIn), .ioIsOut(ioIsOut), .lockedIn(lockedIn),
    .cntDoneIn(cntDoneIn), .countIn(countIn), .doCtrl(doCtrl),
    .word1(word1), .word1Stb(word1Stb), .word2(word2), .word2Stb(word2Stb),
    .doOe(doOe)
  );

  always @(posedge clk) begin
    if (word1Stb) stb1Cnt++;
    if (word2Stb) stb2Cnt++;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic idleOe(input logic [2:0] sel, input logic [1:0] io,
                                  input logic [1:0] isOut, input logic lk,
                                  input logic dn);
    case (sel)
      3'b001:  return !lk;
      3'b010:  return dn;
      3'b101:  return !isOut[0] && !io[0];
      3'b110:  return !isOut[1] && !io[1];
      default: return 1'b0;
    endcase
  endfunction

  task automatic sendBit(input logic b);
    clIn = 1'b0; diIn = b; waitC(H);
    clIn = 1'b1; waitC(H);
  endtask

  task automatic startXfer(input logic [7:0] addr);
    for (int i = 0; i < 8; i++) sendBit(addr[i]);
    clIn = clIdle; waitC(H);
    ceIn = 1'b1; waitC(H);
  endtask

  task automatic endXfer;
    clIn = clIdle; waitC(H);
    ceIn = 1'b0; waitC(3 * H);
  endtask

  task automatic writeWord(input logic [7:0] addr, input logic [23:0] w,
                           input int nBits);
    int s1 = stb1Cnt, s2 = stb2Cnt;
    logic [2:0] savedSel = doCtrl;
    logic savedLk = lockedIn;
    doCtrl = 3'b001; lockedIn = 1'b0;
    startXfer(addr);
    waitC(2);
    // R7 pad released in a write even though the selector would pull low
    if (addr != 8'h2A) check(doOe == 1'b0, "R7/R4 pad during transfer", doOe, 0);
    for (int i = 0; i < nBits; i++) sendBit(i < 24 ? w[i] : 1'b1);
    endXfer();
    doCtrl = savedSel; lockedIn = savedLk; waitC(H);
    if (nBits == 24 && addr == 8'h28) exp1 = w;
    if (nBits == 24 && addr == 8'h29) exp2 = w;
    check(word1 == exp1, "R2/R3/R4 word1", word1, exp1);
    check(word2 == exp2, "R2/R3/R4 word2", word2, exp2);
    check((stb1Cnt - s1) == ((nBits == 24 && addr == 8'h28) ? 1 : 0) &&
          (stb2Cnt - s2) == ((nBits == 24 && addr == 8'h29) ? 1 : 0),
          "R2/R3 strobe count", 32'(stb1Cnt - s1) << 8 | 32'(stb2Cnt - s2), 0);
  endtask

  task automatic readCheck(input logic [1:0] io, input logic lk,
                           input logic [19:0] cnt, input bit wiggle);
    logic [24:0] got = '0;
    logic [24:0] exp = {io[1], io[0], lk, cnt, 2'b11};
    ioPinIn = io; lockedIn = lk; countIn = cnt; waitC(H);
    startXfer(8'h2A);
    // R6 pins change after capture
    if (wiggle) ioPinIn = ~io;
    waitC(H);
    got[24] = !doOe;
    for (int i = 23; i >= 0; i--) begin
      clIn = 1'b0; waitC(H);
      clIn = 1'b1; waitC(H);
      got[i] = !doOe;
    end
    endXfer();
    check(got == exp, "R5/R6 read stream", 32'(got), 32'(exp));
  endtask

  task automatic idleCheck(input logic [2:0] sel, input logic [1:0] io,
                           input logic [1:0] isOut, input logic lk, input logic dn);
    logic e;
    doCtrl = sel; ioPinIn = io; ioIsOut = isOut; lockedIn = lk; cntDoneIn = dn;
    waitC(6);
    e = idleOe(sel, io, isOut, lk, dn);
    check(doOe == e, "R8/R9 idle pad", doOe, e);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    waitC(4);
    // R11 reset state
    check(word1 == 0 && word2 == 0, "R11 words after reset", {word1[15:0], word2[15:0]}, 0);
    check(doOe == 1'b0 && !word1Stb && !word2Stb, "R11 pad/strobes", doOe, 0);
    rstN = 1'b1; waitC(4);

    // R1 R2 directed writes, both modes
    writeWord(8'h28, 24'hA5C3F1, 24);
    writeWord(8'h29, 24'h0F1E2D, 24);
    // R3 short and long
    writeWord(8'h28, 24'h123456, 23);
    writeWord(8'h29, 24'h654321, 25);
    // R4 unknown addresses
    writeWord(8'h2B, 24'hFFFFFF, 24);
    writeWord(8'h14, 24'h000001, 24);
    // R5 R6 reads
    readCheck(2'b10, 1'b1, 20'hD2A3C, 1'b1);
    readCheck(2'b01, 1'b0, 20'h00001, 1'b0);
    // R8 R9 idle codes
    idleCheck(3'b001, 2'b11, 2'b00, 1'b0, 1'b0);
    idleCheck(3'b001, 2'b11, 2'b00, 1'b1, 1'b0);
    idleCheck(3'b010, 2'b11, 2'b00, 1'b1, 1'b1);
    idleCheck(3'b101, 2'b10, 2'b00, 1'b1, 1'b0);
    idleCheck(3'b101, 2'b10, 2'b01, 1'b1, 1'b0);
    idleCheck(3'b110, 2'b01, 2'b10, 1'b1, 1'b0);
    idleCheck(3'b110, 2'b01, 2'b00, 1'b1, 1'b0);
    idleCheck(3'b111, 2'b00, 2'b00, 1'b0, 1'b1);
    ioIsOut = 2'b00; doCtrl = 3'b000; lockedIn = 1'b1; cntDoneIn = 1'b0;

    // R10 resting-high serial clock
    clIdle = 1'b1; clIn = 1'b1; waitC(H);
    writeWord(8'h29, 24'h3C5A69, 24);
    readCheck(2'b11, 1'b1, 20'h7E001, 1'b1);

    // random mix
    for (int it = 0; it < 24; it++) begin
      int r = $urandom_range(0, 3);
      clIdle = 1'($urandom_range(0, 1)); clIn = clIdle; waitC(H);
      case (r)
        0: writeWord(8'h28, 24'($urandom), ($urandom_range(0, 3) == 0) ? 22 + $urandom_range(0, 4) : 24);
        1: writeWord(8'h29, 24'($urandom), ($urandom_range(0, 3) == 0) ? 22 + $urandom_range(0, 4) : 24);
        2: readCheck(2'($urandom), 1'($urandom), 20'($urandom), 1'($urandom));
        default: idleCheck(3'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
      endcase
      ioIsOut = 2'b00; doCtrl = 3'b000; lockedIn = 1'b1; cntDoneIn = 1'b0;
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule